// File: doc/BRIEF.md
# Prioritized Interrupt Target Selector

This block picks, for one interrupt target, the interrupt that the target should claim next. Each cycle it looks at the pending vector, the target's enable mask, a priority value for each source and the target's threshold. The candidates are the sources that are both pending and enabled. Among them it finds the one with the highest priority, breaking ties toward the lowest source index, and reports that index as the claimable ID.

A separate request line tells the target that an interrupt needs attention. It rises only when the selected candidate's priority is strictly above the target threshold. The threshold never changes the reported ID, so a target that reads the ID can still claim an interrupt that sits below its threshold.

Index 0 means "nothing to claim". Source 0 is never a candidate. Both outputs are registered, so they follow the inputs with one cycle of latency.

Top module: `irq_target_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, `sel_id` and `irq_req` are 0.
- R2: A source is a candidate only when its bit is set in both `pend_i` and `en_i`. A source that is pending but disabled, or enabled but not pending, is never reported.
- R3: The reported ID is a candidate whose priority is greater than or equal to that of every other candidate. Source k's priority is `prio_i[k*PW +: PW]`, where PW is the bit width of MAX_PRIO.
- R4: When several candidates share the highest priority, the one with the lowest index is reported.
- R5: With no candidate, `sel_id` is 0 and `irq_req` is 0.
- R6: `irq_req` is 1 exactly when there is a candidate and the selected candidate's priority is strictly greater than `thresh_i`. A priority equal to the threshold gives no request.
- R7: `thresh_i` has no effect on `sel_id`. A below-threshold candidate is still reported.
- R8: A candidate with priority 0 never raises `irq_req`. With `thresh_i` equal to MAX_PRIO, `irq_req` stays 0 for every input.
- R9: Bit 0 of `pend_i` and `en_i` is ignored. Source 0 is never selected.
- R10: Both outputs are registered. Inputs applied before a rising edge show up on the outputs after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | N_SRC | Pending bit per source |
| en_i | input | N_SRC | Target enable bit per source |
| prio_i | input | N_SRC*PW | Packed priorities; source k at bits k*PW +: PW |
| thresh_i | input | PW | Target priority threshold |
| sel_id | output | $clog2(N_SRC) | Registered ID of the best candidate, 0 if none |
| irq_req | output | 1 | Registered request to the target |

## Verification
Two things can happen in the same cycle: the ID selection reports a candidate, and the threshold gate refuses the request for that same candidate. The bench provokes this in two ways. It sweeps every threshold against candidate sets whose winning priority sits just below, equal to and above it. It also sets up ties in which the lowest-index winner has a priority equal to the threshold. In each case it judges the ID and the request separately against values it computes itself. A correct response is a nonzero ID with the request low. Mixing up the two paths would show up either as the ID dropping to 0 or as the request rising when the priority only equals the threshold.

// File: rtl/irq_target_sel.sv
module irq_target_sel #(
  parameter int N_SRC    = 32,
  parameter int MAX_PRIO = 7,
  localparam int PW      = $clog2(MAX_PRIO + 1),
  localparam int IDW     = $clog2(N_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SRC-1:0]    pend_i,
  input  logic [N_SRC-1:0]    en_i,
  input  logic [N_SRC*PW-1:0] prio_i,
  input  logic [PW-1:0]       thresh_i,
  output logic [IDW-1:0]      sel_id,
  output logic                irq_req
);
  localparam int LEAVES = 1 << IDW;

  logic           nv [1:2*LEAVES-1];
  logic [PW-1:0]  np [1:2*LEAVES-1];
  logic [IDW-1:0] ni [1:2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    localparam logic [IDW-1:0] LID = i[IDW-1:0];
    if (i < N_SRC) begin : g_real
      assign nv[LEAVES+i] = pend_i[i] & en_i[i] & (i != 0);
      assign np[LEAVES+i] = prio_i[i*PW +: PW];
    end else begin : g_pad
      assign nv[LEAVES+i] = 1'b0;
      assign np[LEAVES+i] = '0;
    end
    assign ni[LEAVES+i] = LID;
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+1] & (~nv[2*k] | (np[2*k+1] > np[2*k]));
    assign nv[k]  = nv[2*k] | nv[2*k+1];
    assign np[k]  = take_r ? np[2*k+1] : np[2*k];
    assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_id  <= '0;
      irq_req <= 1'b0;
    end else begin
      sel_id  <= nv[1] ? ni[1] : '0;
      irq_req <= nv[1] & (np[1] > thresh_i);
    end
  end
endmodule

module irq_target_sel_chk #(
  parameter int N_SRC    = 32,
  parameter int MAX_PRIO = 7,
  localparam int PW      = $clog2(MAX_PRIO + 1),
  localparam int IDW     = $clog2(N_SRC)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_SRC-1:0]    pend_i,
  input logic [N_SRC-1:0]    en_i,
  input logic [N_SRC*PW-1:0] prio_i,
  input logic [PW-1:0]       thresh_i,
  input logic [IDW-1:0]      sel_id,
  input logic                irq_req
);
  logic                pv;
  logic [N_SRC-1:0]    pcand;
  logic [N_SRC*PW-1:0] pprio;
  logic [PW-1:0]       pthr;
  logic [PW-1:0]       psel;
  logic                higher, tie_low;

  always_ff @(posedge clk) begin
    pv    <= rst_n;
    pcand <= pend_i & en_i & ~N_SRC'(1);
    pprio <= prio_i;
    pthr  <= thresh_i;
  end

  assign psel = pprio[sel_id*PW +: PW];

  always_comb begin
    higher  = 1'b0;
    tie_low = 1'b0;
    for (int j = 1; j < N_SRC; j++) begin
      if (pcand[j] && pprio[j*PW +: PW] > psel) higher = 1'b1;
      if (pcand[j] && pprio[j*PW +: PW] == psel && j < int'(sel_id)) tie_low = 1'b1;
    end
  end

  assert_cand_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && sel_id != '0) |-> pcand[sel_id]);
  assert_best_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && sel_id != '0) |-> !higher);
  assert_tie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && sel_id != '0) |-> !tie_low);
  assert_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && pcand == '0) |-> (sel_id == '0 && !irq_req));
  assert_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && irq_req) |-> (sel_id != '0 && psel > pthr));
  assert_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && sel_id != '0 && psel > pthr) |-> irq_req);
  assert_zero_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> psel != '0);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (sel_id == '0 && !irq_req));
endmodule

bind irq_target_sel irq_target_sel_chk #(.N_SRC(N_SRC), .MAX_PRIO(MAX_PRIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .prio_i(prio_i),
  .thresh_i(thresh_i), .sel_id(sel_id), .irq_req(irq_req)
);

// File: tb/irq_target_sel_tb.sv
`timescale 1ns/1ps
module irq_target_sel_tb;
  localparam int N = 8;
  localparam int MP = 7;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0, en = '0;
  logic [N*PW-1:0] prio = '0;
  logic [PW-1:0] thr = '0;
  logic [2:0]    sel_id;
  logic          irq_req;
  int            n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_target_sel #(.N_SRC(N), .MAX_PRIO(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
    .thresh_i(thr), .sel_id(sel_id), .irq_req(irq_req));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(output int eid, output int ereq);
    int bp = -1;
    eid = 0;
    for (int i = 1; i < N; i++)
      if (pend[i] && en[i] && int'(prio[i*PW +: PW]) > bp) begin
        bp = int'(prio[i*PW +: PW]);
        eid = i;
      end
    ereq = (eid != 0 && bp > int'(thr)) ? 1 : 0;
  endfunction

  task automatic run(input string tag);
    int eid, ereq;
    model(eid, ereq);
    @(negedge clk);
    chk({tag, " id"}, int'(sel_id), eid);
    chk({tag, " req"}, int'(irq_req), ereq);
  endtask

  task automatic setp(input int s);
    for (int i = 0; i < N; i++) begin
      int v;
      case (s)
        0: v = (i * 3) % 8;
        1: v = 5;
        2: v = i;
        3: v = 7 - i;
        default: v = (i % 2) ? 0 : 4;
      endcase
      prio[i*PW +: PW] = PW'(v);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    pend = '1; en = '1; setp(2);
    repeat (3) @(negedge clk);
    chk("R1 reset id", int'(sel_id), 0);
    chk("R1 reset req", int'(irq_req), 0);
    rst_n = 1'b1;
    pend = '0; en = '0;
    chk("R1 first cycle req", int'(irq_req), 0);
    run("R5 empty");

    setp(2); thr = 0;
    pend = 8'b1010_0100; en = 8'b1111_1111; run("R3 highest");
    setp(1); pend = 8'b0110_1000; run("R4 tie lowest");
    setp(2); pend = 8'b1111_0000; en = 8'b0111_1111; run("R2 disabled skipped");
    pend = 8'b0000_0001; en = 8'b0000_0001; run("R9 source0 ignored");
    chk("R9 id zero", int'(sel_id), 0);
    setp(2); pend = 8'b0010_0000; en = '1; thr = 5; run("R6 equal no req");
    chk("R7 id kept", int'(sel_id), 5);
    thr = 4; run("R6 above req");
    setp(4); pend = 8'b0000_0010; thr = 0; run("R8 prio0 no req");
    chk("R8 prio0 id", int'(sel_id), 1);
    setp(2); pend = '1; thr = 7; run("R8 max thresh");
    chk("R8 max thresh req", int'(irq_req), 0);

    pend = 8'b0000_1000; thr = 0;
    @(negedge clk);
    pend = 8'b0100_0000;
    #1 chk("R10 before edge", int'(sel_id), 3);
    @(negedge clk);
    chk("R10 after edge", int'(sel_id), 6);

    for (int s = 0; s < 5; s++) begin
      setp(s);
      for (int m = 0; m < 256; m++) begin
        pend = N'(m);
        en = (s % 2) ? '1 : N'(m * 37 + 11);
        thr = PW'((m + s) % 8);
        run("R2 R3 R4 R6 R7 sweep");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule